// File: doc/BRIEF.md
# Hysteretic Relay Grid Accumulator

This block evaluates a discretized, relaxation-free hysteresis model. Each sample is a signed field value scaled to the open interval (-1, 1). The block holds a rectangular grid of two-state relay elements. Each relay is indexed by a coercive threshold row and an interaction offset column, and keeps a single state bit between samples. For every accepted sample the block updates each relay against the shifted field. It adds the precomputed weight of every relay that is set, then forms the output. That output is the field times a programmable inverse-slope gain, minus one, plus twice the weighted sum, saturated to a signed sample.

The grid is swept in fixed lane groups, several relays per clock. With the defaults (32 x 32 relays, 128 lanes) one sample is accepted every 8 cycles. A new sample may be taken in the cycle that finishes the previous one. The coercive, interaction and weight tables and the gain are loaded through a small write port while the block is idle. Only nonnegative interaction magnitudes are stored: half of the columns use them as positive offsets and the other half use them negated.

Top module: `hyst_relay_accum`

## Requirements
- R1: On synchronous reset `out_valid` is 0, `out_data` is 0, `in_ready` is 1, the gain is 0 and every relay state bit is cleared.
- R2: A sample is taken on a clock edge with `in_valid` and `in_ready` both high. `in_ready` is low in the cycle after acceptance, and it is high again in the last group cycle, so samples can be accepted every NC*NI/LANES cycles (8 by default).
- R3: `out_valid` is a one-cycle pulse on the edge exactly NC*NI/LANES clock edges after the acceptance edge.
- R4: Relay (c, j) sets when field + offset(j) > coercive(c), clears when field + offset(j) < -coercive(c), and otherwise keeps its state. Equality holds the state.
- R5: For column j < NI/2 the offset is +mag[j]. For column j >= NI/2 the offset is -mag[j-NI/2].
- R6: `out_data` = floor(field*gain / 2^13) - 2^13 + floor(S / 2^8), where S is the sum of the weights of set relays. Field and output are Q1.13, gain is unsigned Q3.13 and weights are unsigned Q0.22.
- R7: That result saturates to the range [-8192, 8191] instead of wrapping.
- R8: The write port uses `wr_sel` 0 for coercive[wr_addr], 1 for mag[wr_addr], 2 for weight[wr_addr] (relay index c*NI + j) and 3 for the gain. A write takes effect only when the block is not busy with a sample; writes issued while busy change nothing.
- R9: `out_data` holds its value between result pulses.
- R10: Relay states persist across samples, so the same field gives different outputs after different histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Field sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_field | input | 14 | Signed Q1.13 field sample |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select: 0 coercive, 1 interaction, 2 weight, 3 gain |
| wr_addr | input | 10 | Table entry index |
| wr_data | input | 22 | Write value (low bits used for narrow tables) |
| out_valid | output | 1 | Result pulse |
| out_data | output | 14 | Signed Q1.13 result |

## Verification
Each result is due on the eighth rising edge after the edge that took its sample. `in_ready` drops one edge after acceptance and returns after the seventh edge. The bench counts falling edges from acceptance, so it checks ready low at count 0, ready high and no result at count 7, and the result and data at count 8. It then expects the pulse to be gone one edge later. Table writes issued during the group sweep are compared against a model that leaves the tables unchanged.

// File: rtl/hyst_relay_accum.sv
module hyst_relay_accum #(
  parameter int FW    = 14,
  parameter int TW    = 13,
  parameter int WW    = 22,
  parameter int GNW   = 16,
  parameter int NC    = 32,
  parameter int NI    = 32,
  parameter int LANES = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [FW-1:0] in_field,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [$clog2(NC*NI)-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  output logic          out_valid,
  output logic [FW-1:0] out_data
);
  localparam int NREL = NC * NI;
  localparam int NIH  = NI / 2;
  localparam int NG   = NREL / LANES;
  localparam int AW   = $clog2(NREL);
  localparam int GW   = NG > 1 ? $clog2(NG) : 1;
  localparam int CW   = NC > 1 ? $clog2(NC) : 1;
  localparam int JW   = NI > 1 ? $clog2(NI) : 1;
  localparam int MW   = NIH > 1 ? $clog2(NIH) : 1;
  localparam int ACCW = WW + 1;
  localparam int FRAC = FW - 1;
  localparam int SH   = WW - FW;
  localparam int ONE  = 1 << FRAC;
  localparam int MAXV = ONE - 1;
  localparam int MINV = -ONE;

  logic [TW-1:0] coer [NC];
  logic [TW-1:0] mag  [NIH];
  logic [WW-1:0] wt   [NREL];
  logic [NREL-1:0] rly;
  logic [GNW-1:0]  gain;
  logic signed [FW-1:0] field_q;
  logic [GW-1:0]   grp;
  logic            busy;
  logic [ACCW-1:0] acc, gsum, acc_fin;
  logic [AW-1:0]   lane_idx [LANES];
  logic            lane_nxt [LANES];
  logic signed [31:0] prod, total;
  logic [FW-1:0]   sat_val;

  wire last   = busy && (grp == GW'(NG - 1));
  wire accept = in_valid && in_ready;
  assign in_ready = !busy || last;

  always_comb begin
    gsum = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [AW-1:0] idx;
      logic [CW-1:0] c;
      logic [JW-1:0] j;
      int off, s, ec;
      idx = AW'(grp) * AW'(LANES) + AW'(l);
      c   = CW'(idx / AW'(NI));
      j   = JW'(idx % AW'(NI));
      if (j < JW'(NIH)) off = int'(mag[MW'(j)]);
      else              off = -int'(mag[MW'(j - JW'(NIH))]);
      s  = int'(field_q) + off;
      ec = int'(coer[c]);
      lane_idx[l] = idx;
      if (s > ec)       lane_nxt[l] = 1'b1;
      else if (s < -ec) lane_nxt[l] = 1'b0;
      else              lane_nxt[l] = rly[idx];
      if (lane_nxt[l]) gsum = gsum + ACCW'(wt[idx]);
    end
  end

  assign acc_fin = acc + gsum;
  assign prod  = 32'(field_q) * 32'($signed({1'b0, gain}));
  assign total = (prod >>> FRAC) - 32'sd0 - ONE + $signed(32'(acc_fin >> SH));
  assign sat_val = (total > MAXV) ? FW'(MAXV) :
                   (total < MINV) ? FW'(MINV) : total[FW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      grp       <= '0;
      acc       <= '0;
      rly       <= '0;
      gain      <= '0;
      field_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (busy) begin
        for (int l = 0; l < LANES; l++) rly[lane_idx[l]] <= lane_nxt[l];
        acc <= acc_fin;
        if (last) begin
          out_valid <= 1'b1;
          out_data  <= sat_val;
          busy      <= 1'b0;
          grp       <= '0;
        end else begin
          grp <= grp + 1'b1;
        end
      end
      if (accept) begin
        busy    <= 1'b1;
        grp     <= '0;
        acc     <= '0;
        field_q <= in_field;
      end
      if (!busy && wr_en && wr_sel == 2'd3) gain <= wr_data[GNW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && wr_en) begin
      case (wr_sel)
        2'd0: coer[wr_addr[CW-1:0]] <= wr_data[TW-1:0];
        2'd1: mag[wr_addr[MW-1:0]]  <= wr_data[TW-1:0];
        2'd2: wt[wr_addr]           <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hyst_relay_accum_chk.sv
module hyst_relay_accum_chk #(
  parameter int NG = 8,
  parameter int FW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [FW-1:0] out_data
);
  logic [7:0] cnt;
  logic       act;
  wire acc_ok = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (acc_ok) begin
      cnt <= '0;
      act <= 1'b1;
    end else if (act && cnt != 8'hFF) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (rst)
    acc_ok |=> !in_ready);  // R2
  AST_READY_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    (act && cnt == 8'(NG - 1)) |-> in_ready);  // R2
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(act) && $past(cnt) == 8'(NG - 1)));  // R3
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);  // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));  // R9
endmodule

bind hyst_relay_accum hyst_relay_accum_chk #(.NG(NC * NI / LANES), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/hyst_relay_accum_tb.sv
module hyst_relay_accum_tb;
  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready;
  logic [13:0] in_field = '0;
  logic wr_en = 0;
  logic [1:0] wr_sel = '0;
  logic [9:0] wr_addr = '0;
  logic [21:0] wr_data = '0;
  logic out_valid;
  logic [13:0] out_data;

  int n_chk = 0, n_bad = 0;
  int ecv [32];
  int mg  [16];
  int wv  [1024];
  int st  [1024];
  int gain_m = 0;
  int last_out = 0;
  int exp_v;

  always #5 clk = ~clk;

  hyst_relay_accum u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_field(in_field), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_addr = 10'(addr); wr_data = 22'(data);
    @(posedge clk); #1 wr_en = 0;
  endtask

  function automatic int model_step(input int f);
    int s = 0, lin, t;
    for (int r = 0; r < 1024; r++) begin
      int c = r / 32, j = r % 32, off, x;
      off = (j < 16) ? mg[j] : -mg[j - 16];   // R5 mirrored columns
      x = f + off;
      if (x > ecv[c]) st[r] = 1;              // R4 strict set
      else if (x < -ecv[c]) st[r] = 0;        // R4 strict clear
      if (st[r] != 0) s += wv[r];
    end
    lin = (f * gain_m) >>> 13;
    t = lin - 8192 + (s >>> 8);
    if (t > 8191) t = 8191;                   // R7
    if (t < -8192) t = -8192;
    return t;
  endfunction

  task automatic sample(input int f, input bit poke);
    @(negedge clk);
    in_valid = 1; in_field = 14'(f);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    exp_v = model_step(f);
    for (int k = 0; k <= 8; k++) begin
      @(negedge clk);
      if (k == 0) begin
        in_valid = 0;
        chk("R2 ready low after accept", int'(in_ready), 0);
      end
      if (poke && k == 2) begin
        wr_en = 1; wr_sel = 2'd2; wr_addr = 10'd0; wr_data = 22'h3FFFFF;
      end
      if (poke && k == 3) begin
        wr_sel = 2'd3; wr_data = 22'd65535;
      end
      if (poke && k == 4) wr_en = 0;
      if (k == 4) chk("R9 data held", int'($signed(out_data)), last_out);
      if (k == 7) begin
        chk("R2 ready at last group", int'(in_ready), 1);
        chk("R3 no early result", int'(out_valid), 0);
      end
      if (k == 8) begin
        chk("R3 result due", int'(out_valid), 1);
        chk("R6 result value", int'($signed(out_data)), exp_v);
      end
    end
    @(negedge clk);
    chk("R3 single pulse", int'(out_valid), 0);
    last_out = exp_v;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a, b;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 out_valid reset", int'(out_valid), 0);
    chk("R1 out_data reset", int'(out_data), 0);
    chk("R1 ready reset", int'(in_ready), 1);

    for (int c = 0; c < 32; c++) begin ecv[c] = 200 * c + 50; wr(0, c, ecv[c]); end
    for (int k = 0; k < 16; k++) begin mg[k] = 300 * k; wr(1, k, mg[k]); end
    for (int r = 0; r < 1024; r++) begin wv[r] = (r * 37 + 11) % 4097; wr(2, r, wv[r]); end
    for (int r = 0; r < 1024; r++) st[r] = 0;

    // R1: gain still 0, all relays cleared, field -max cannot set any
    sample(-8192, 0);
    chk("R1 cleared relays give -one", last_out, -8192);

    gain_m = 4096; wr(3, 0, gain_m);
    // R4 R5 R6: major sweep up and down
    for (int f = -8192; f <= 8191; f += 1024) sample(f, 0);
    for (int f = 8191; f >= -8192; f -= 1024) sample(f, 0);
    // R4 boundaries around relay 0 threshold
    sample(49, 0); sample(50, 0); sample(51, 0); sample(-50, 0); sample(-51, 0);
    // R10 history dependence
    sample(8191, 0); sample(0, 0); a = last_out;
    sample(-8192, 0); sample(0, 0); b = last_out;
    chk("R10 history differs", int'(a != b), 1);
    // minor loops
    for (int f = -2000; f <= 3000; f += 700) sample(f, 0);
    for (int f = 3000; f >= -1000; f -= 900) sample(f, 0);
    // R8: writes while busy are ignored
    sample(8191, 1);
    sample(3000, 0);
    sample(8191, 0);
    // R7 saturation
    gain_m = 65535; wr(3, 0, gain_m);
    sample(8191, 0);
    chk("R7 positive clamp", last_out, 8191);
    sample(-8192, 0);
    chk("R7 negative clamp", last_out, -8192);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule